// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer. Its clock is the output of a dual-modulus prescaler that divides the oscillator signal by 32 or by 33. The block drives the prescaler's modulus select and counts the prescaler output pulses. It emits one comparison pulse for every N oscillator cycles, where N = 32·M + S.

A swallow counter keeps the prescaler at 33 for the first S prescaler outputs of each comparison period. The main counter then runs the rest of the M-count period at 32. Over one period the oscillator therefore sees S·33 + (M−S)·32 = 32·M + S input cycles. The usable continuous range of N is 992 to 262143.

The divide values S and M are taken from the inputs only at a period boundary, so a change in the middle of a period cannot corrupt the count. A synchronous clear from standby restarts the period at once. A flag reports a divide pair that breaks the rules S ≤ M and M ≥ 3.

Top module: `pswallow_div`

## Requirements
- R1: With legal values, one comparison period lasts exactly M clocks, and the modulus select is high for exactly S of them. The oscillator division is therefore 32·M + S.
- R2: `mod_sel` = 1 selects divide-by-33 and `mod_sel` = 0 selects divide-by-32. Within each period it is high for the first S clocks and low for the remaining clocks. Once low, it stays low until the next load.
- R3: `cmp_pulse` is high for exactly one clock per period. That clock is the first clock of the following period.
- R4: `swal_in` and `main_in` are sampled only at the end of a period, or on clear or reset. A change in the middle of a period does not alter the length or the modulus pattern of the current period.
- R5: With S = 0, `mod_sel` stays low for the whole period. With S = M, it stays high for the whole period.
- R6: A synchronous `clr` ends the current period immediately. The next period is loaded from the present inputs. `cmp_pulse` is low in the clock after the clear.
- R7: A synchronous `rst` acts as a load. In the clock after reset, `cmp_pulse` = 0, `mod_sel` = (S ≠ 0), and `div_err` reflects the inputs.
- R8: At each load, `div_err` is set to 1 when S > M or M < 3, and to 0 otherwise. It holds that value until the next load.
- R9: A main value below 3 is run as a period of 3 clocks.
- R10: When S > M, `mod_sel` is high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, used as the clock |
| rst | input | 1 | Synchronous active-high reset, which loads the counters |
| clr | input | 1 | Synchronous clear from standby, which restarts the period |
| swal_in | input | SW_W (5) | Swallow value S |
| main_in | input | MN_W (13) | Main value M |
| cmp_pulse | output | 1 | One-clock comparison pulse per period |
| mod_sel | output | 1 | Prescaler modulus select: 1 = divide by 33, 0 = divide by 32 |
| div_err | output | 1 | Illegal divide pair in the values last loaded |

## Verification
The embedded assertions check properties on every cycle. They confirm that the comparison pulse is one clock wide and is suppressed by a clear, and that the modulus select never returns high inside a period once it has dropped. They also confirm that the first clock of a new period carries the modulus implied by the swallow value just sampled, and that the error flag moves only at loads. Only the bench scenarios can show the whole-period quantities: period length, the count of divide-by-33 clocks, that mid-period input changes are deferred, and the behaviour with clamped or out-of-order S and M. The bench also compares all three outputs against a behavioural model on every clock.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {
    MOD_DIV32 = 1'b0,
    MOD_DIV33 = 1'b1
  } modulus_e;
endpackage

// File: rtl/psd_load_chk.sv
module psd_load_chk #(
  parameter int SW_W     = 5,
  parameter int MN_W     = 13,
  parameter int MAIN_MIN = 3
) (
  input  logic [SW_W-1:0] swal_in,
  input  logic [MN_W-1:0] main_in,
  output logic [MN_W-1:0] main_eff,
  output logic            bad
);
  localparam logic [MN_W-1:0] MIN_V = MN_W'(MAIN_MIN);

  logic [MN_W-1:0] swal_ext;
  logic            too_small;

  assign swal_ext = MN_W'(swal_in);

  always_comb begin
    too_small = (main_in < MIN_V);
    bad       = too_small || (swal_ext > main_in);
    main_eff  = too_small ? MIN_V : main_in;
  end
endmodule

// File: rtl/psd_main_cnt.sv
module psd_main_cnt #(
  parameter int MN_W = 13
) (
  input  logic            clk,
  input  logic            load,
  input  logic [MN_W-1:0] main_eff,
  output logic            term
);
  logic [MN_W-1:0] cnt_q;

  // counts M-1 down to 0; zero is the last clock of the period
  always_ff @(posedge clk) begin
    if (load) cnt_q <= main_eff - 1'b1;
    else      cnt_q <= cnt_q - 1'b1;
  end

  assign term = (cnt_q == '0);
endmodule

// File: rtl/psd_swal_cnt.sv
module psd_swal_cnt
  import psd_pkg::*;
#(
  parameter int SW_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [SW_W-1:0] swal_in,
  output logic            mod_sel
);
  logic [SW_W-1:0] cnt_q;
  modulus_e        mod_q;

  // counts the divide-by-33 clocks left in this period; the select flop
  // tracks the next count value so it stays a registered output
  always_ff @(posedge clk) begin
    if (load) begin
      cnt_q <= swal_in;
      mod_q <= (swal_in != '0) ? MOD_DIV33 : MOD_DIV32;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      mod_q <= (cnt_q > SW_W'(1)) ? MOD_DIV33 : MOD_DIV32;
    end
  end

  assign mod_sel = mod_q;

  AST_MOD_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (mod_q == MOD_DIV32 && !load) |=> (mod_q == MOD_DIV32)); // R2
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int SW_W     = 5,
  parameter int MN_W     = 13,
  parameter int MAIN_MIN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [SW_W-1:0] swal_in,
  input  logic [MN_W-1:0] main_in,
  output logic            cmp_pulse,
  output logic            mod_sel,
  output logic            div_err
);
  logic [MN_W-1:0] main_eff;
  logic            bad;
  logic            term;
  logic            load;
  logic            pulse_q;
  logic            err_q;

  psd_load_chk #(.SW_W(SW_W), .MN_W(MN_W), .MAIN_MIN(MAIN_MIN)) u_chk (
    .swal_in  (swal_in),
    .main_in  (main_in),
    .main_eff (main_eff),
    .bad      (bad)
  );

  // reset, clear and terminal count all reload both counters
  assign load = rst || clr || term;

  psd_main_cnt #(.MN_W(MN_W)) u_main (
    .clk      (clk),
    .load     (load),
    .main_eff (main_eff),
    .term     (term)
  );

  psd_swal_cnt #(.SW_W(SW_W)) u_swal (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .swal_in (swal_in),
    .mod_sel (mod_sel)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) pulse_q <= 1'b0;
    else            pulse_q <= term;
    if (load)       err_q   <= bad;
  end

  assign cmp_pulse = pulse_q;
  assign div_err   = err_q;

  AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |=> !cmp_pulse); // R3
  AST_CLR_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    clr |=> !cmp_pulse); // R6
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(div_err)); // R8
  AST_NEW_PERIOD_MOD: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |-> (mod_sel == ($past(swal_in) != '0))); // R2
endmodule

// File: tb/pswallow_div_test.sv
module pswallow_div_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [4:0]  s_in = 5'd5;
  logic [12:0] m_in = 13'd10;
  logic        cmp_pulse, mod_sel, div_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  int pos = 0, mcur = 3, scur = 0;
  bit e_pulse = 0, e_mod = 0, e_err = 0, valid = 0;

  always #2 clk = ~clk;

  pswallow_div uut (
    .clk(clk), .rst(rst), .clr(clr), .swal_in(s_in), .main_in(m_in),
    .cmp_pulse(cmp_pulse), .mod_sel(mod_sel), .div_err(div_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    int mi, si;
    mi = int'(m_in);
    si = int'(s_in);
    if (rst || clr || pos == mcur - 1) begin
      e_pulse = !(rst || clr);
      mcur = (mi < 3) ? 3 : mi;
      scur = si;
      e_err = (si > mi) || (mi < 3);
      pos = 0;
    end else begin
      e_pulse = 1'b0;
      pos++;
    end
    e_mod = (pos < scur);
    valid = 1'b1;
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (valid && !done) begin
      check("R3 cmp_pulse vs model", int'(cmp_pulse), int'(e_pulse));
      check("R2 mod_sel vs model", int'(mod_sel), int'(e_mod));
      check("R8 div_err vs model", int'(div_err), int'(e_err));
    end
  end

  task automatic sync_pulse();
    @(negedge clk);
    while (!cmp_pulse) @(negedge clk);
  endtask

  task automatic measure(input string tag, input int exp_len, input int exp_hi);
    int len = 0;
    int hi = 0;
    sync_pulse();
    do begin
      hi += int'(mod_sel);
      len++;
      @(negedge clk);
    end while (!cmp_pulse);
    check({tag, " period length"}, len, exp_len);
    check({tag, " divide-by-33 clocks"}, hi, exp_hi);
  endtask

  initial begin
    int len, hi, n;
    repeat (3) @(negedge clk);
    // R7: state held during reset
    check("R7 pulse in reset", int'(cmp_pulse), 0);
    check("R7 mod_sel in reset", int'(mod_sel), 1);
    check("R7 err in reset", int'(div_err), 0);
    rst = 1'b0;

    measure("R1 S5 M10", 10, 5);
    measure("R1 S5 M10 again", 10, 5);

    s_in = 5'd0; m_in = 13'd7;
    measure("R5 S0", 7, 0);
    s_in = 5'd6; m_in = 13'd6;
    measure("R5 S=M", 6, 6);

    // R4: change mid-period, current period unaffected
    s_in = 5'd2; m_in = 13'd20;
    sync_pulse();
    len = 0; hi = 0;
    do begin
      hi += int'(mod_sel);
      len++;
      if (len == 5) begin s_in = 5'd4; m_in = 13'd9; end
      @(negedge clk);
    end while (!cmp_pulse);
    check("R4 old period length", len, 20);
    check("R4 old mod33 count", hi, 2);
    measure("R4 new values", 9, 4);

    s_in = 5'd0; m_in = 13'd1;
    measure("R9 M below min", 3, 0);
    check("R8 err on M<3", int'(div_err), 1);

    s_in = 5'd9; m_in = 13'd4;
    measure("R10 S>M", 4, 4);
    check("R8 err on S>M", int'(div_err), 1);

    s_in = 5'd3; m_in = 13'd12;
    measure("R1 S3 M12", 12, 3);
    check("R8 err cleared", int'(div_err), 0);

    // R6: clear in mid-period, reload from present inputs
    sync_pulse();
    repeat (4) @(negedge clk);
    clr = 1'b1; s_in = 5'd1; m_in = 13'd5;
    @(negedge clk);
    clr = 1'b0;
    check("R6 no pulse after clear", int'(cmp_pulse), 0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cmp_pulse);
    check("R6 period after clear", n, 5);
    measure("R6 following period", 5, 1);

    finish_run();
  end
endmodule